// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This block settles the outcome of a PC-relative branch for a 64-bit machine with fixed 32-bit instructions. From the current instruction address, the six-bit major opcode, the 21-bit displacement field and the 64-bit contents of the tested register, it produces four results. The first is the branch destination. The second is a taken flag. The third is the address of the instruction that will actually run next. The fourth is a request to write a return address into a register.

A single adder forms the destination for every branch flavour. A condition stage, steered by the opcode, runs one of four kinds of test. Two unconditional forms always take the branch and save a return address. Two forms look only at the least significant bit. Six forms compare the register with zero as a signed integer. Six more forms compare it with zero as an IEEE double. Fetch, register reads, prediction and return-address tracking are all handled outside this block. A parameter selects one of two timing modes. In the first, the results are purely combinational. In the second, they are held in a register stage and appear one clock after the inputs.

Top module: `branch_resolver`

## Requirements
- R1: The destination output equals pc + 4 + (displacement sign-extended from bit 20 and multiplied by 4), computed modulo 2^64. It is driven for every opcode, taken or not.
- R2: Opcodes 0x30 and 0x34 behave the same way. Both are always taken, the next address equals the destination, and both raise the link-write request with the register number from the instruction and data pc + 4.
- R3: Opcode 0x38 is taken exactly when bit 0 of the tested value is 0. Opcode 0x3C is taken exactly when that bit is 1. No other bit has any effect on these two.
- R4: The integer forms read the value as signed 64-bit and compare it with zero. The mapping is: 0x39 equal, 0x3A less than, 0x3B less or equal, 0x3D not equal, 0x3E greater or equal, 0x3F greater than.
- R5: The float forms apply the same six relations, with the same low three opcode bits, to a double compared with 0.0. The opcodes are 0x31 eq, 0x32 lt, 0x33 le, 0x35 ne, 0x36 ge and 0x37 gt. A value counts as zero when bits 62:0 are all 0, so +0.0 and -0.0 are both zero. A non-zero value is negative when bit 63 is 1.
- R6: When the branch is not taken, the next address is pc + 4 and the destination output still shows the computed target.
- R7: Opcodes 0x00 to 0x2F are not branches. For these, taken stays low, no link write is requested, and the next address is pc + 4.
- R8: A link write is requested only for the two unconditional forms and never for any conditional form. Whenever a link write is requested, taken is also high.
- R9: While in_valid is low, taken and the link-write request stay low whatever the opcode is.
- R10: With REG_OUT=1, every output reflects the inputs sampled at the previous rising clock edge. Synchronous reset clears taken, the link-write request, the link fields and both address outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present on the inputs |
| pc_i | input | 64 | Address of the branch instruction |
| opcode_i | input | 6 | Major opcode |
| disp_i | input | 21 | Word displacement field |
| ra_idx_i | input | REG_IDX_W (5) | Register number of the tested/link register |
| ra_val_i | input | 64 | Value read from that register |
| target_o | output | 64 | Computed branch destination |
| taken_o | output | 1 | Branch resolved taken |
| next_pc_o | output | 64 | Address to fetch next |
| link_we_o | output | 1 | Single-cycle link-write request |
| link_idx_o | output | REG_IDX_W (5) | Register to receive the return address |
| link_data_o | output | 64 | Return address (pc + 4) |

## Verification
Some cases are hard to reach from the ports. The float relations must treat negative zero and negative subnormals differently, even though both have only the sign bit and a few low bits set. The address sum must also wrap past 2^64. The bench reaches these cases by sweeping every opcode against a fixed set of bit patterns: both signed zeros, the smallest subnormals of each sign, ±1.0 and the extreme integers. It combines each pattern with displacement and pc pairs that hit the most negative displacement, the largest positive displacement, and a pc just below the top of the address space. Expected outcomes come from signed arithmetic and real-number comparison in the bench. Patterns that decode as NaN are left out for the float opcodes.

// File: rtl/bru_pkg.sv
package bru_pkg;

    localparam int XLEN       = 64;
    localparam int OPC_W      = 6;
    localparam int DISP_W     = 21;
    localparam int INSN_BYTES = 4;
    localparam int INSN_SHIFT = 2;
    localparam int EXT_W      = XLEN - DISP_W - INSN_SHIFT;

    typedef enum logic [2:0] {
        BK_NONE,
        BK_ALWAYS,
        BK_LOWCLR,
        BK_LOWSET,
        BK_INT,
        BK_FP
    } br_kind_e;

    // Relation code equals the low three opcode bits of the compare forms
    typedef enum logic [2:0] {
        RL_NONE = 3'd0,
        RL_EQ   = 3'd1,
        RL_LT   = 3'd2,
        RL_LE   = 3'd3,
        RL_RSV  = 3'd4,
        RL_NE   = 3'd5,
        RL_GE   = 3'd6,
        RL_GT   = 3'd7
    } br_rel_e;

    typedef struct packed {
        br_kind_e kind;
        br_rel_e  rel;
        logic     links;
    } br_decode_t;

    typedef struct packed {
        logic is_zero;
        logic is_neg;
    } sign_class_t;

    typedef struct packed {
        logic [XLEN-1:0] target;
        logic [XLEN-1:0] next_pc;
        logic [XLEN-1:0] link_data;
        logic            taken;
        logic            link_we;
    } br_result_t;

    function automatic br_decode_t decode_op(input logic [OPC_W-1:0] op);
        br_decode_t d;
        d.kind  = BK_NONE;
        d.rel   = RL_NONE;
        d.links = 1'b0;
        if (op[5:4] == 2'b11) begin
            unique case (op[2:0])
                3'd0: begin
                    d.kind  = op[3] ? BK_LOWCLR : BK_ALWAYS;
                    d.links = ~op[3];
                end
                3'd4: begin
                    d.kind  = op[3] ? BK_LOWSET : BK_ALWAYS;
                    d.links = ~op[3];
                end
                default: begin
                    d.kind = op[3] ? BK_INT : BK_FP;
                    d.rel  = br_rel_e'(op[2:0]);
                end
            endcase
        end
        return d;
    endfunction

    function automatic sign_class_t classify_int(input logic [XLEN-1:0] v);
        sign_class_t c;
        c.is_zero = (v == '0);
        c.is_neg  = v[XLEN-1];
        return c;
    endfunction

    function automatic sign_class_t classify_fp(input logic [XLEN-1:0] v);
        sign_class_t c;
        c.is_zero = (v[XLEN-2:0] == '0);
        c.is_neg  = v[XLEN-1] & ~c.is_zero;
        return c;
    endfunction

    function automatic logic rel_holds(input br_rel_e rel, input sign_class_t c);
        logic r;
        case (rel)
            RL_EQ:   r = c.is_zero;
            RL_LT:   r = c.is_neg;
            RL_LE:   r = c.is_neg | c.is_zero;
            RL_NE:   r = ~c.is_zero;
            RL_GE:   r = ~c.is_neg;
            RL_GT:   r = ~c.is_neg & ~c.is_zero;
            default: r = 1'b0;
        endcase
        return r;
    endfunction

    function automatic logic [XLEN-1:0] disp_offset(input logic [DISP_W-1:0] d);
        return {{EXT_W{d[DISP_W-1]}}, d, {INSN_SHIFT{1'b0}}};
    endfunction

endpackage

// File: rtl/bru_decode.sv
module bru_decode
    import bru_pkg::*;
(
    input  logic [OPC_W-1:0] opcode_i,
    output br_decode_t       dec_o
);
    assign dec_o = decode_op(opcode_i);
endmodule

// File: rtl/bru_target.sv
module bru_target
    import bru_pkg::*;
(
    input  logic [XLEN-1:0]   pc_i,
    input  logic [DISP_W-1:0] disp_i,
    output logic [XLEN-1:0]   seq_pc_o,
    output logic [XLEN-1:0]   target_o
);
    assign seq_pc_o = pc_i + XLEN'(INSN_BYTES);
    assign target_o = seq_pc_o + disp_offset(disp_i);
endmodule

// File: rtl/bru_cond.sv
module bru_cond
    import bru_pkg::*;
(
    input  br_kind_e        kind_i,
    input  br_rel_e         rel_i,
    input  logic [XLEN-1:0] val_i,
    output logic            pass_o
);
    sign_class_t sc_int;
    sign_class_t sc_fp;

    always_comb begin
        sc_int = classify_int(val_i);
        sc_fp  = classify_fp(val_i);
        case (kind_i)
            BK_ALWAYS: pass_o = 1'b1;
            BK_LOWCLR: pass_o = ~val_i[0];
            BK_LOWSET: pass_o = val_i[0];
            BK_INT:    pass_o = rel_holds(rel_i, sc_int);
            BK_FP:     pass_o = rel_holds(rel_i, sc_fp);
            default:   pass_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
    import bru_pkg::*;
#(
    parameter int REG_IDX_W = 5,
    parameter bit REG_OUT   = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [XLEN-1:0]      pc_i,
    input  logic [OPC_W-1:0]     opcode_i,
    input  logic [DISP_W-1:0]    disp_i,
    input  logic [REG_IDX_W-1:0] ra_idx_i,
    input  logic [XLEN-1:0]      ra_val_i,
    output logic [XLEN-1:0]      target_o,
    output logic                 taken_o,
    output logic [XLEN-1:0]      next_pc_o,
    output logic                 link_we_o,
    output logic [REG_IDX_W-1:0] link_idx_o,
    output logic [XLEN-1:0]      link_data_o
);

    br_decode_t      dec;
    logic            pass;
    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] target;
    br_result_t      res_c;

    bru_decode u_decode (
        .opcode_i (opcode_i),
        .dec_o    (dec)
    );

    bru_target u_target (
        .pc_i     (pc_i),
        .disp_i   (disp_i),
        .seq_pc_o (seq_pc),
        .target_o (target)
    );

    bru_cond u_cond (
        .kind_i (dec.kind),
        .rel_i  (dec.rel),
        .val_i  (ra_val_i),
        .pass_o (pass)
    );

    always_comb begin
        res_c.target    = target;
        res_c.taken     = in_valid & pass;
        res_c.next_pc   = res_c.taken ? target : seq_pc;
        res_c.link_we   = in_valid & dec.links;
        res_c.link_data = seq_pc;
    end

    generate
        if (REG_OUT) begin : g_reg
            br_result_t            res_q;
            logic [REG_IDX_W-1:0]  idx_q;
            logic                  armed;

            always_ff @(posedge clk) begin
                if (rst) begin
                    res_q <= '0;
                    idx_q <= '0;
                    armed <= 1'b0;
                end else begin
                    res_q <= res_c;
                    idx_q <= ra_idx_i;
                    armed <= 1'b1;
                end
            end

            assign target_o    = res_q.target;
            assign taken_o     = res_q.taken;
            assign next_pc_o   = res_q.next_pc;
            assign link_we_o   = res_q.link_we;
            assign link_idx_o  = res_q.link_we ? idx_q : '0;
            assign link_data_o = res_q.link_we ? res_q.link_data : '0;

            // R1
            target_sum_chk: assert property (@(posedge clk) disable iff (rst || !armed)
                target_o == $past(pc_i) + XLEN'(INSN_BYTES) + disp_offset($past(disp_i)));

            // R6
            fallthrough_chk: assert property (@(posedge clk) disable iff (rst || !armed)
                !taken_o |-> next_pc_o == $past(pc_i) + XLEN'(INSN_BYTES));

            // R7
            nonbranch_quiet_chk: assert property (@(posedge clk) disable iff (rst || !armed)
                ($past(opcode_i[5:4]) != 2'b11) |-> (!taken_o && !link_we_o));

            // R8
            link_implies_taken_chk: assert property (@(posedge clk) disable iff (rst)
                link_we_o |-> taken_o);

            // R2
            link_payload_chk: assert property (@(posedge clk) disable iff (rst || !armed)
                link_we_o |-> (link_data_o == $past(pc_i) + XLEN'(INSN_BYTES)
                               && link_idx_o == $past(ra_idx_i)));

            // R9
            idle_quiet_chk: assert property (@(posedge clk) disable iff (rst || !armed)
                !$past(in_valid) |-> (!taken_o && !link_we_o));

            // R10
            reset_clear_chk: assert property (@(posedge clk)
                rst |=> (!taken_o && !link_we_o && target_o == '0 && next_pc_o == '0));
        end else begin : g_comb
            assign target_o    = res_c.target;
            assign taken_o     = res_c.taken;
            assign next_pc_o   = res_c.next_pc;
            assign link_we_o   = res_c.link_we;
            assign link_idx_o  = res_c.link_we ? ra_idx_i : '0;
            assign link_data_o = res_c.link_we ? res_c.link_data : '0;

            always_comb begin
                if (!rst) begin
                    // R8
                    comb_link_taken_chk: assert (!link_we_o || taken_o);
                end
            end
        end
    endgenerate

endmodule

// File: tb/branch_resolver_tb.sv
module branch_resolver_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] pc_i = '0;
    logic [5:0]  opcode_i = '0;
    logic [20:0] disp_i = '0;
    logic [4:0]  ra_idx_i = '0;
    logic [63:0] ra_val_i = '0;
    logic [63:0] target_o;
    logic        taken_o;
    logic [63:0] next_pc_o;
    logic        link_we_o;
    logic [4:0]  link_idx_o;
    logic [63:0] link_data_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    branch_resolver #(.REG_IDX_W(5), .REG_OUT(1'b1)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .pc_i(pc_i),
        .opcode_i(opcode_i), .disp_i(disp_i), .ra_idx_i(ra_idx_i),
        .ra_val_i(ra_val_i), .target_o(target_o), .taken_o(taken_o),
        .next_pc_o(next_pc_o), .link_we_o(link_we_o),
        .link_idx_o(link_idx_o), .link_data_o(link_data_o)
    );

    logic [63:0] vals [12];
    logic [63:0] pcs  [5];
    logic [20:0] disps[5];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic bit is_nan(input logic [63:0] v);
        return (v[62:52] == 11'h7FF) && (v[51:0] != 0);
    endfunction

    function automatic bit model_taken(input logic [5:0] op, input logic [63:0] v);
        longint s;
        real r;
        s = $signed(v);
        r = $bitstoreal(v);
        case (op)
            6'h30, 6'h34: return 1'b1;
            6'h38: return v[0] == 1'b0;
            6'h3C: return v[0] == 1'b1;
            6'h39: return s == 0;
            6'h3A: return s < 0;
            6'h3B: return s <= 0;
            6'h3D: return s != 0;
            6'h3E: return s >= 0;
            6'h3F: return s > 0;
            6'h31: return r == 0.0;
            6'h32: return r < 0.0;
            6'h33: return r <= 0.0;
            6'h35: return r != 0.0;
            6'h36: return r >= 0.0;
            6'h37: return r > 0.0;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string req_of(input logic [5:0] op);
        if (op < 6'h30) return "R7";
        if (op == 6'h30 || op == 6'h34) return "R2";
        if (op == 6'h38 || op == 6'h3C) return "R3";
        if (op[3]) return "R4";
        return "R5";
    endfunction

    task automatic run_vec(input logic v, input logic [63:0] pc, input logic [5:0] op,
                           input logic [20:0] d, input logic [4:0] idx, input logic [63:0] val);
        logic [63:0] tgt;
        logic [63:0] seq;
        bit tk;
        bit lw;
        @(negedge clk);
        in_valid = v; pc_i = pc; opcode_i = op; disp_i = d; ra_idx_i = idx; ra_val_i = val;
        seq = pc + 64'd4;
        tgt = seq + (64'($signed(d)) * 64'd4);
        tk  = v && model_taken(op, val);
        lw  = v && (op == 6'h30 || op == 6'h34);
        @(negedge clk);
        // R1 target always presented; R10 one-cycle latency
        chk(target_o == tgt, "R1", "target", target_o, tgt);
        if (!v) begin
            // R9
            chk(!taken_o && !link_we_o, "R9", "idle taken/link", {62'd0, taken_o, link_we_o}, 64'd0);
        end else begin
            chk(taken_o == tk, req_of(op), "taken", 64'(taken_o), 64'(tk));
            // R8 link only for the unconditional forms
            chk(link_we_o == lw, "R8", "link_we", 64'(link_we_o), 64'(lw));
        end
        if (tk) chk(next_pc_o == tgt, "R2", "next_pc taken", next_pc_o, tgt);
        // R6
        else chk(next_pc_o == seq, "R6", "next_pc fallthrough", next_pc_o, seq);
        if (lw) begin
            chk(link_data_o == seq, "R2", "link_data", link_data_o, seq);
            chk(link_idx_o == idx, "R2", "link_idx", 64'(link_idx_o), 64'(idx));
        end
    endtask

    initial begin
        #(20 * 190000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        vals[0]  = 64'h0000_0000_0000_0000;
        vals[1]  = 64'h8000_0000_0000_0000;
        vals[2]  = 64'h0000_0000_0000_0001;
        vals[3]  = 64'h8000_0000_0000_0001;
        vals[4]  = 64'h3FF0_0000_0000_0000;
        vals[5]  = 64'hBFF0_0000_0000_0000;
        vals[6]  = 64'hFFFF_FFFF_FFFF_FFFF;
        vals[7]  = 64'h7FFF_FFFF_FFFF_FFFF;
        vals[8]  = 64'h0000_0000_0000_0002;
        vals[9]  = 64'hFFFF_FFFF_FFFF_FFFE;
        vals[10] = 64'h0000_0001_0000_0000;
        vals[11] = 64'h4000_0000_0000_0003;
        pcs[0] = 64'h0000_0000_0000_1000; disps[0] = 21'h000000;
        pcs[1] = 64'h0000_0000_0000_1000; disps[1] = 21'h0FFFFF;
        pcs[2] = 64'h0000_0000_0040_0000; disps[2] = 21'h100000;
        pcs[3] = 64'hFFFF_FFFF_FFFF_FFF8; disps[3] = 21'h000001;
        pcs[4] = 64'h1234_5678_9ABC_DEF0; disps[4] = 21'h1FFFFF;

        repeat (3) @(negedge clk);
        // R10 reset state
        chk(!taken_o && !link_we_o, "R10", "reset taken/link", {62'd0, taken_o, link_we_o}, 64'd0);
        chk(target_o == 0 && next_pc_o == 0, "R10", "reset addresses", target_o | next_pc_o, 64'd0);
        rst = 1'b0;

        // Sweep: all opcodes x bit patterns x address geometries (R1-R8 covered per vector)
        for (int op = 0; op < 64; op++) begin
            for (int vi = 0; vi < 12; vi++) begin
                for (int gi = 0; gi < 5; gi++) begin
                    if ((op >= 6'h31 && op <= 6'h37 && op != 6'h34) && is_nan(vals[vi])) continue;
                    run_vec(1'b1, pcs[gi], 6'(op), disps[gi], 5'((op + vi + gi) % 32), vals[vi]);
                end
            end
        end

        // R3: upper bits ignored by the low-bit forms
        run_vec(1'b1, 64'h2000, 6'h38, 21'h10, 5'd3, 64'hFFFF_FFFF_FFFF_FFFE);
        run_vec(1'b1, 64'h2000, 6'h3C, 21'h10, 5'd3, 64'h0000_0000_0000_0001);
        run_vec(1'b1, 64'h2000, 6'h3C, 21'h10, 5'd3, 64'hFFFF_FFFF_FFFF_FFFE);

        // R9: valid low over every branch opcode
        for (int op = 6'h30; op < 64; op++)
            run_vec(1'b0, 64'h3000, 6'(op), 21'h4, 5'd7, 64'd0);

        // R10: output holds old result until the clock edge
        run_vec(1'b1, 64'h4000, 6'h30, 21'h8, 5'd9, 64'd0);
        @(negedge clk);
        opcode_i = 6'h00; in_valid = 1'b1;
        #2;
        chk(taken_o == 1'b1, "R10", "hold before edge", 64'(taken_o), 64'd1);
        @(negedge clk);
        chk(taken_o == 1'b0, "R10", "update after edge", 64'(taken_o), 64'd0);

        // R10: reset in mid-stream clears outputs
        run_vec(1'b1, 64'h5000, 6'h34, 21'h2, 5'd11, 64'd0);
        rst = 1'b1;
        @(negedge clk);
        chk(!taken_o && !link_we_o && link_data_o == 0 && link_idx_o == 0, "R10", "reset mid-run",
            {61'd0, taken_o, link_we_o, |link_idx_o}, 64'd0);
        rst = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule